// File: doc/BRIEF.md
# Mirrored-Input Barrel Shifter

This block is a 64-bit combinational shifter. It has only one shift network, and that network moves bits toward the most significant end. A right shift uses the same network. The operand's bit order is reversed before it enters the network, and the network's output is reversed again to form the result. This saves a second shift network at the cost of two sets of reversal wiring and a few multiplexers.

The shift distance runs from 0 to 63. A direction input selects left or right. For right shifts, an arithmetic flag selects a sign fill in place of a zero fill. The sign fill costs almost nothing: the fill value the network injects at the vacated low end is set to the operand's top bit. Once the output is reversed, that low end becomes the high end of the result. There are no registers inside, so the result follows the inputs in the same cycle.

Top module: `mirror_shift_unit`

## Requirements
- R1: With `dir_right_i` = 0, `result_o` equals `opnd_i` shifted toward bit 63 by `amt_i` positions, and the `amt_i` lowest result bits are 0.
- R2: With `dir_right_i` = 1 and `arith_i` = 0, `result_o` equals `opnd_i` shifted toward bit 0 by `amt_i` positions, and the `amt_i` highest result bits are 0.
- R3: With `dir_right_i` = 1 and `arith_i` = 1, `result_o` equals `opnd_i` shifted toward bit 0 by `amt_i` positions, and each of the `amt_i` highest result bits equals `opnd_i[63]`.
- R4: When `amt_i` = 0, `result_o` equals `opnd_i` for every combination of `dir_right_i` and `arith_i`.
- R5: With `dir_right_i` = 0, `arith_i` has no effect on `result_o`.
- R6: At `amt_i` = 63, each mode gives its own result. A left shift leaves only `opnd_i[0]` in bit 63. A logical right shift leaves only `opnd_i[63]` in bit 0. An arithmetic right shift copies `opnd_i[63]` into all 64 bits.
- R7: Each bit k of `amt_i` adds a displacement of 2^k positions, independently of the other bits, so every value from 0 to 63 gives its exact distance in all three modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Operand to shift |
| amt_i | input | 6 | Shift distance, 0 to 63 |
| dir_right_i | input | 1 | 0 = shift toward bit 63, 1 = shift toward bit 0 |
| arith_i | input | 1 | For right shifts, 1 = fill with `opnd_i[63]`; ignored for left shifts |
| result_o | output | 64 | Shifted result |

## Verification
The immediate assertions inside the shifter assume that all inputs carry known 0/1 values whenever the logic settles. Each check is skipped while any input is unknown. The bench drives every input to a defined value from time zero and changes inputs only away from the sampling point, so the checks always see settled, known data. The fill checks also assume that `amt_i` never exceeds 63. The 6-bit port guarantees this, and the bench sweeps the full range, including both end points.

// File: rtl/mshift_pkg.sv
`timescale 1ns/1ps
package mshift_pkg;
  parameter int unsigned DATA_W  = 64;
  parameter int unsigned AMT_W   = $clog2(DATA_W);
  localparam int unsigned STAGES = AMT_W;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [AMT_W-1:0]  dist_t;

  typedef enum logic [1:0] {
    MODE_LEFT   = 2'b00,
    MODE_RLOGIC = 2'b01,
    MODE_RARITH = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/bit_mirror.sv
`timescale 1ns/1ps
module bit_mirror #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] in_i,
  input  logic             flip_i,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0] swapped;

  for (genvar b = 0; b < WIDTH; b++) begin : g_swap
    assign swapped[b] = in_i[WIDTH-1-b];
  end

  assign out_o = flip_i ? swapped : in_i;

  // R2: a flipped word keeps its end bits exchanged
  always_comb begin
    if (!$isunknown({in_i, flip_i}) && flip_i) begin
      mirror_ends_chk: assert (out_o[0] == in_i[WIDTH-1] && out_o[WIDTH-1] == in_i[0])
        else $error("mirror end bits not exchanged");
    end
  end
endmodule

// File: rtl/lsh_stage.sv
`timescale 1ns/1ps
module lsh_stage #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DIST  = 1
) (
  input  logic [WIDTH-1:0] din_i,
  input  logic             en_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [WIDTH-1:0] moved;

  assign moved  = {din_i[WIDTH-1-DIST:0], {DIST{fill_i}}};
  assign dout_o = en_i ? moved : din_i;

  // R3: an enabled stage injects the fill value at its low end
  always_comb begin
    if (!$isunknown({din_i, en_i, fill_i}) && en_i) begin
      stage_fill_chk: assert (dout_o[DIST-1:0] == {DIST{fill_i}})
        else $error("stage %0d fill mismatch", DIST);
    end
  end

  // R7: an enabled stage displaces by exactly its own distance
  always_comb begin
    if (!$isunknown({din_i, en_i, fill_i}) && en_i) begin
      stage_dist_chk: assert (dout_o[WIDTH-1] == din_i[WIDTH-1-DIST])
        else $error("stage %0d distance wrong", DIST);
    end
  end
endmodule

// File: rtl/lsh_network.sv
`timescale 1ns/1ps
module lsh_network #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [WIDTH-1:0] chain [0:AMT_W];

  assign chain[0] = din_i;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    lsh_stage #(
      .WIDTH (WIDTH),
      .DIST  (1 << s)
    ) stage_i (
      .din_i  (chain[s]),
      .en_i   (amt_i[s]),
      .fill_i (fill_i),
      .dout_o (chain[s+1])
    );
  end

  assign dout_o = chain[AMT_W];

  // R4: zero distance passes the word through the network untouched
  always_comb begin
    if (!$isunknown({din_i, amt_i, fill_i}) && amt_i == '0) begin
      net_pass_chk: assert (dout_o == din_i)
        else $error("network altered data at zero distance");
    end
  end
endmodule

// File: rtl/mirror_shift_unit.sv
`timescale 1ns/1ps
module mirror_shift_unit
  import mshift_pkg::*;
(
  input  logic [63:0] opnd_i,
  input  logic [5:0]  amt_i,
  input  logic        dir_right_i,
  input  logic        arith_i,
  output logic [63:0] result_o
);
  localparam int unsigned W = DATA_W;
  localparam int unsigned A = AMT_W;

  shift_mode_e mode;
  word_t       net_in;
  word_t       net_out;
  logic        fill_bit;

  always_comb begin
    if (!dir_right_i)  mode = MODE_LEFT;
    else if (arith_i)  mode = MODE_RARITH;
    else               mode = MODE_RLOGIC;
  end

  assign fill_bit = (mode == MODE_RARITH) ? opnd_i[W-1] : 1'b0;

  bit_mirror #(.WIDTH(W)) pre_mirror_i (
    .in_i   (opnd_i),
    .flip_i (dir_right_i),
    .out_o  (net_in)
  );

  lsh_network #(.WIDTH(W), .AMT_W(A)) net_i (
    .din_i  (net_in),
    .amt_i  (amt_i),
    .fill_i (fill_bit),
    .dout_o (net_out)
  );

  bit_mirror #(.WIDTH(W)) post_mirror_i (
    .in_i   (net_out),
    .flip_i (dir_right_i),
    .out_o  (result_o)
  );

  word_t low_mask;
  word_t high_mask;
  logic  inputs_known;

  always_comb begin
    low_mask     = (word_t'(1) << amt_i) - word_t'(1);
    high_mask    = ~(~word_t'(0) >> amt_i);
    inputs_known = !$isunknown({opnd_i, amt_i, dir_right_i, arith_i});
  end

  // R4
  always_comb begin
    if (inputs_known && amt_i == '0) begin
      zero_amt_chk: assert (result_o == opnd_i)
        else $error("zero distance changed operand");
    end
  end

  // R1
  always_comb begin
    if (inputs_known && !dir_right_i) begin
      left_zero_fill_chk: assert ((result_o & low_mask) == '0)
        else $error("left shift low bits not zero");
    end
  end

  // R2
  always_comb begin
    if (inputs_known && dir_right_i && !arith_i) begin
      rlog_zero_fill_chk: assert ((result_o & high_mask) == '0)
        else $error("logical right shift high bits not zero");
    end
  end

  // R3
  always_comb begin
    if (inputs_known && dir_right_i && arith_i) begin
      rari_sign_fill_chk: assert ((result_o & high_mask) == (opnd_i[W-1] ? high_mask : '0))
        else $error("arithmetic right shift fill wrong");
    end
  end
endmodule

// File: tb/mirror_shift_unit_tb_top.sv
`timescale 1ns/1ps
module mirror_shift_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [63:0] opnd;
  logic [5:0]  amt;
  logic        dir_r;
  logic        arith;
  logic [63:0] res;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  mirror_shift_unit dut_i (
    .opnd_i      (opnd),
    .amt_i       (amt),
    .dir_right_i (dir_r),
    .arith_i     (arith),
    .result_o    (res)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] model(input logic [63:0] v, input int d,
                                        input logic r, input logic a);
    if (!r)     return v << d;
    else if (a) return 64'($signed(v) >>> d);
    else        return v >> d;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] v, input int d, input logic r, input logic a);
    @(negedge clk);
    opnd  = v;
    amt   = 6'(d);
    dir_r = r;
    arith = a;
    #2;
  endtask

  task automatic t_reset_state;
    apply(64'h0, 0, 1'b0, 1'b0);
    check("R4 reset-state zero", res, 64'h0);
  endtask

  task automatic t_zero_amount;
    logic [63:0] v = 64'hF00D_1234_8765_ABCD;
    for (int m = 0; m < 4; m++) begin
      apply(v, 0, m[1], m[0]);
      check("R4 zero distance", res, v);
    end
  endtask

  task automatic t_left;
    apply(64'h0123_4567_89AB_CDEF, 4, 1'b0, 1'b0);
    check("R1 left by 4", res, 64'h1234_5678_9ABC_DEF0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 40, 1'b0, 1'b0);
    check("R1 left by 40", res, 64'hFFFF_FF00_0000_0000);
  endtask

  task automatic t_right_logical;
    apply(64'h8000_0000_0000_0001, 1, 1'b1, 1'b0);
    check("R2 logical right by 1", res, 64'h4000_0000_0000_0000);
    apply(64'hFEDC_BA98_7654_3210, 16, 1'b1, 1'b0);
    check("R2 logical right by 16", res, 64'h0000_FEDC_BA98_7654);
  endtask

  task automatic t_right_arith;
    apply(64'hFEDC_BA98_7654_3210, 16, 1'b1, 1'b1);
    check("R3 arith right negative", res, 64'hFFFF_FEDC_BA98_7654);
    apply(64'h7EDC_BA98_7654_3210, 8, 1'b1, 1'b1);
    check("R3 arith right positive", res, 64'h007E_DCBA_9876_5432);
  endtask

  task automatic t_arith_ignored_left;
    logic [63:0] v = 64'h8421_0000_FFFF_1357;
    apply(v, 13, 1'b0, 1'b1);
    check("R5 arith flag on left", res, v << 13);
    apply(v, 13, 1'b0, 1'b0);
    check("R5 arith flag off left", res, v << 13);
  endtask

  task automatic t_max_amount;
    apply(64'h8000_0000_0000_0001, 63, 1'b0, 1'b0);
    check("R6 left 63", res, 64'h8000_0000_0000_0000);
    apply(64'h8000_0000_0000_0001, 63, 1'b1, 1'b0);
    check("R6 logical right 63", res, 64'h1);
    apply(64'h8000_0000_0000_0000, 63, 1'b1, 1'b1);
    check("R6 arith right 63", res, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_sweep;
    logic [63:0] pats [3] = '{64'hA5C3_0F96_1E2D_B487, 64'h1, 64'h8000_0000_0000_0000};
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < 64; d++) begin
        for (int m = 0; m < 3; m++) begin
          logic r = (m != 0);
          logic a = (m == 2);
          apply(pats[p], d, r, a);
          check("R7 distance sweep", res, model(pats[p], d, r, a));
        end
      end
    end
  endtask

  initial begin
    opnd  = '0;
    amt   = '0;
    dir_r = 1'b0;
    arith = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_zero_amount();
    t_left();
    t_right_logical();
    t_right_arith();
    t_arith_ignored_left();
    t_max_amount();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule